// File: doc/BRIEF.md
# Displacement Address and Bit-Test Unit

This unit forms the effective address of a register-plus-displacement memory access and carries out that access on a simple synchronous memory port. A request gives a 32-bit base value, a 16-bit signed displacement, an operation kind, a 3-bit bit index and 32-bit store data. The displacement is sign-extended and added to the base. The sum wraps modulo 2^32 and raises no fault.

Two operations are supported. An aligned word store forces the two low address bits to zero and writes the full store word. A bit test reads the word that holds the addressed byte and picks that byte by the low address bits, in little-endian lane order. It then reports the inverse of the indexed bit on a Z flag. A bit test never writes memory and changes no other state. The unit takes one request at a time and holds its strobes until the memory answers with ready.

Top module: `dispaddr_bittest`

## Requirements
- R1: The effective address equals base + sign-extended displacement, modulo 2^32 (bit 15 of the displacement is the sign bit). For a bit test, this address appears unchanged on `mem_addr`.
- R2: For a word store (`req_kind`=0), `mem_addr` is the effective address with bits 1:0 cleared, `mem_wdata` is the store data, `mem_wr`=1 and `mem_rd`=0.
- R3: For a bit test (`req_kind`=1), `mem_rd`=1 and `mem_wr`=0. The unit never asserts both strobes at once.
- R4: On completion of a bit test, `zflag` is the inverse of bit `bit_idx` of byte lane `mem_addr[1:0]` of `mem_rdata`. Lane n is `mem_rdata[8n+7:8n]`.
- R5: `zflag` changes only on the edge that completes a bit test. It holds during the wait and across word stores.
- R6: A request is accepted when `req_valid` is high and the unit is idle. `busy` rises one cycle after acceptance and stays high until the completing edge. `req_ready` is the inverse of `busy`, and a request presented while busy is ignored.
- R7: While a strobe is high and `mem_ready` is low, the strobes, `mem_addr` and `mem_wdata` stay stable. The edge on which `mem_ready` is high ends the access and drops the strobes.
- R8: After reset, `busy`, `mem_rd`, `mem_wr`, `done` and `zflag` are all 0.
- R9: `done` is high for exactly one cycle, directly after the completing edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle, request can be taken |
| req_kind | input | 1 | 0 = word store, 1 = bit test |
| base_val | input | 32 | Base register value |
| disp_val | input | 16 | Signed displacement |
| bit_idx | input | 3 | Bit index within the byte |
| store_val | input | 32 | Word to store |
| busy | output | 1 | Operation in progress |
| mem_addr | output | 32 | Memory address |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data |
| mem_ready | input | 1 | Memory completes the access |
| zflag | output | 1 | Bit-test result flag |
| done | output | 1 | One-cycle completion pulse |

## Verification
The address, strobes, write data and `busy` are due one edge after the accepting edge. The bench samples them on the falling edge that follows. `zflag`, the drop of `busy` and the `done` pulse are due one edge after the edge on which `mem_ready` is high. The bench therefore raises `mem_ready` on a falling edge, lets one rising edge pass, and checks on the next falling edge. It then checks `done` again one cycle later. Wait states of zero to three cycles are inserted, and stability is checked on every waiting cycle.

// File: rtl/dab_pkg.sv
package dab_pkg;
   typedef enum logic {
      OP_STORE = 1'b0,
      OP_BTEST = 1'b1
   } op_kind_t;
endpackage

// File: rtl/dab_ea_adder.sv
module dab_ea_adder #(
   parameter int ADDR_W = 32,
   parameter int DISP_W = 16
) (
   input  logic [ADDR_W-1:0] base_i,
   input  logic [DISP_W-1:0] disp_i,
   output logic [ADDR_W-1:0] ea_o
);
   localparam int EXT_W = ADDR_W - DISP_W;

   logic [ADDR_W-1:0] disp_ext;

   generate
      if (EXT_W > 0) begin : g_ext
         assign disp_ext = {{EXT_W{disp_i[DISP_W-1]}}, disp_i};
      end else begin : g_noext
         assign disp_ext = disp_i;
      end
   endgenerate

   // modulo 2^ADDR_W, carry out dropped on purpose
   assign ea_o = base_i + disp_ext;
endmodule

// File: rtl/dab_byte_pick.sv
module dab_byte_pick #(
   parameter int DATA_W = 32,
   parameter int LANES  = DATA_W / 8,
   parameter int LANE_W = (LANES > 1) ? $clog2(LANES) : 1
) (
   input  logic [DATA_W-1:0] word_i,
   input  logic [LANE_W-1:0] lane_i,
   input  logic [2:0]        idx_i,
   output logic              bit_o
);
   logic [7:0] lane_bytes [LANES];
   logic [7:0] sel_byte;

   generate
      for (genvar g = 0; g < LANES; g++) begin : g_lane
         assign lane_bytes[g] = word_i[8*g +: 8];
      end
      if (LANES > 1) begin : g_mux
         assign sel_byte = lane_bytes[lane_i];
      end else begin : g_single
         logic unused_lane;
         assign unused_lane = ^lane_i;
         assign sel_byte    = lane_bytes[0];
      end
   endgenerate

   assign bit_o = sel_byte[idx_i];
endmodule

// File: rtl/dab_ctrl.sv
module dab_ctrl
   import dab_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int LANE_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept_i,
   input  op_kind_t          kind_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic              mem_ready_i,
   input  logic              picked_bit_i,
   output logic              busy_o,
   output logic              rd_o,
   output logic              wr_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic [DATA_W-1:0] wdata_o,
   output logic [LANE_W-1:0] lane_o,
   output logic              z_o,
   output logic              done_o
);
   logic finish;

   assign finish = busy_o && mem_ready_i;
   assign lane_o = addr_o[LANE_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_o  <= 1'b0;
         rd_o    <= 1'b0;
         wr_o    <= 1'b0;
         addr_o  <= '0;
         wdata_o <= '0;
         z_o     <= 1'b0;
         done_o  <= 1'b0;
      end else begin
         done_o <= 1'b0;
         if (accept_i) begin
            busy_o  <= 1'b1;
            rd_o    <= (kind_i == OP_BTEST);
            wr_o    <= (kind_i == OP_STORE);
            addr_o  <= addr_i;
            wdata_o <= wdata_i;
         end else if (finish) begin
            busy_o <= 1'b0;
            rd_o   <= 1'b0;
            wr_o   <= 1'b0;
            done_o <= 1'b1;
            if (rd_o) begin
               z_o <= ~picked_bit_i;
            end
         end
      end
   end
endmodule

// File: rtl/dispaddr_bittest.sv
module dispaddr_bittest
   import dab_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DISP_W = 16,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_kind,
   input  logic [ADDR_W-1:0] base_val,
   input  logic [DISP_W-1:0] disp_val,
   input  logic [2:0]        bit_idx,
   input  logic [DATA_W-1:0] store_val,
   output logic              busy,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic              mem_ready,
   output logic              zflag,
   output logic              done
);
   localparam int LANES  = DATA_W / 8;
   localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1;
   localparam int ALIGN_W = (LANES > 1) ? $clog2(LANES) : 0;

   generate
      if (DATA_W % 8 != 0 || DATA_W < 8) begin : g_bad_data
         $error("DATA_W must be a positive multiple of 8");
      end
      if (DISP_W > ADDR_W || DISP_W < 1) begin : g_bad_disp
         $error("DISP_W must lie in 1..ADDR_W");
      end
      if ((1 << ALIGN_W) != LANES) begin : g_bad_lanes
         $error("DATA_W/8 must be a power of two");
      end
   endgenerate

   op_kind_t          kind;
   logic [ADDR_W-1:0] ea;
   logic [ADDR_W-1:0] issue_addr;
   logic [LANE_W-1:0] lane_q;
   logic [2:0]        idx_q;
   logic              picked;
   logic              accept;

   assign kind      = op_kind_t'(req_kind);
   assign accept    = req_valid && !busy;
   assign req_ready = !busy;

   dab_ea_adder #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_add (
      .base_i (base_val),
      .disp_i (disp_val),
      .ea_o   (ea)
   );

   generate
      if (ALIGN_W > 0) begin : g_align
         assign issue_addr = (kind == OP_STORE) ? {ea[ADDR_W-1:ALIGN_W], {ALIGN_W{1'b0}}} : ea;
      end else begin : g_noalign
         assign issue_addr = ea;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q <= '0;
      end else if (accept) begin
         idx_q <= bit_idx;
      end
   end

   dab_byte_pick #(.DATA_W(DATA_W), .LANES(LANES), .LANE_W(LANE_W)) u_pick (
      .word_i (mem_rdata),
      .lane_i (lane_q),
      .idx_i  (idx_q),
      .bit_o  (picked)
   );

   dab_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANE_W(LANE_W)) u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .accept_i     (accept),
      .kind_i       (kind),
      .addr_i       (issue_addr),
      .wdata_i      (store_val),
      .mem_ready_i  (mem_ready),
      .picked_bit_i (picked),
      .busy_o       (busy),
      .rd_o         (mem_rd),
      .wr_o         (mem_wr),
      .addr_o       (mem_addr),
      .wdata_o      (mem_wdata),
      .lane_o       (lane_q),
      .z_o          (zflag),
      .done_o       (done)
   );
endmodule

// File: rtl/dab_chk.sv
module dab_chk #(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              req_ready,
   input logic              mem_rd,
   input logic              mem_wr,
   input logic              mem_ready,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [DATA_W-1:0] mem_wdata,
   input logic              zflag,
   input logic              done
);
   // R3
   excl_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd && mem_wr));

   // R2
   store_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr |-> (mem_addr[1:0] == 2'b00));

   // R7
   hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((mem_rd || mem_wr) && !mem_ready) |=>
         ($stable(mem_addr) && $stable(mem_wdata) && $stable(mem_rd) && $stable(mem_wr)));

   // R5
   z_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd && mem_ready) |=> $stable(zflag));

   // R9
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((mem_rd || mem_wr) && mem_ready) |=> (done && !busy && !mem_rd && !mem_wr));

   // R9
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R6
   ready_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready != busy);

   // R6
   busy_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (mem_rd || mem_wr));
endmodule

bind dispaddr_bittest dab_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dab_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .busy      (busy),
   .req_ready (req_ready),
   .mem_rd    (mem_rd),
   .mem_wr    (mem_wr),
   .mem_ready (mem_ready),
   .mem_addr  (mem_addr),
   .mem_wdata (mem_wdata),
   .zflag     (zflag),
   .done      (done)
);

// File: tb/dispaddr_bittest_tb_top.sv
`timescale 1ns/1ps
module dispaddr_bittest_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic        req_kind = 1'b0;
   logic [31:0] base_val = '0;
   logic [15:0] disp_val = '0;
   logic [2:0]  bit_idx = '0;
   logic [31:0] store_val = '0;
   logic        busy;
   logic [31:0] mem_addr;
   logic        mem_rd;
   logic        mem_wr;
   logic [31:0] mem_wdata;
   logic [31:0] mem_rdata = '0;
   logic        mem_ready = 1'b0;
   logic        zflag;
   logic        done;

   int n_chk = 0;
   int n_err = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   dispaddr_bittest dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_kind(req_kind), .base_val(base_val), .disp_val(disp_val),
      .bit_idx(bit_idx), .store_val(store_val), .busy(busy),
      .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
      .zflag(zflag), .done(done)
   );

   typedef struct packed {
      logic        kind;
      logic [31:0] base;
      logic [15:0] disp;
      logic [2:0]  idx;
      logic [31:0] sdata;
      logic [31:0] rdata;
      logic [31:0] eaddr;
      logic        ez;
      logic [1:0]  wt;
   } vec_t;

   localparam int NV = 8;
   localparam vec_t VECS [NV] = '{
      '{1'b0, 32'h0000_1000, 16'h0010, 3'd0, 32'hDEAD_BEEF, 32'h0,         32'h0000_1010, 1'b0, 2'd0},
      '{1'b0, 32'h0000_1003, 16'h0002, 3'd0, 32'hCAFE_F00D, 32'h0,         32'h0000_1004, 1'b0, 2'd1},
      '{1'b0, 32'h0000_0002, 16'hFFFF, 3'd0, 32'h0BAD_C0DE, 32'h0,         32'h0000_0000, 1'b0, 2'd2},
      '{1'b1, 32'h0000_2000, 16'h0001, 3'd3, 32'h0,         32'h0000_0800, 32'h0000_2001, 1'b0, 2'd0},
      '{1'b1, 32'h0000_2000, 16'h0003, 3'd7, 32'h0,         32'h7FFF_FFFF, 32'h0000_2003, 1'b1, 2'd3},
      '{1'b1, 32'hFFFF_FFFE, 16'h0004, 3'd0, 32'h0,         32'h0001_0000, 32'h0000_0002, 1'b0, 2'd1},
      '{1'b1, 32'h0000_0010, 16'h8000, 3'd5, 32'h0,         32'hFFFF_FFDF, 32'hFFFF_8010, 1'b1, 2'd0},
      '{1'b0, 32'hFFFF_FFFF, 16'h0003, 3'd0, 32'h1234_5678, 32'h0,         32'h0000_0000, 1'b1, 2'd2}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic run_vec(input vec_t v, input int num);
      @(negedge clk);
      req_valid = 1'b1;
      req_kind  = v.kind;
      base_val  = v.base;
      disp_val  = v.disp;
      bit_idx   = v.idx;
      store_val = v.sdata;
      @(negedge clk);
      req_valid = 1'b0;
      store_val = 32'h5555_AAAA;
      base_val  = 32'h0;
      chk($sformatf("R6 busy after accept v%0d", num), {31'b0, busy}, 32'd1);
      chk($sformatf("R6 req_ready low v%0d", num), {31'b0, req_ready}, 32'd0);
      chk($sformatf("R1 R2 mem_addr v%0d", num), mem_addr, v.eaddr);
      chk($sformatf("R3 mem_rd v%0d", num), {31'b0, mem_rd}, {31'b0, v.kind});
      chk($sformatf("R2 mem_wr v%0d", num), {31'b0, mem_wr}, {31'b0, ~v.kind});
      if (!v.kind) chk($sformatf("R2 mem_wdata v%0d", num), mem_wdata, v.sdata);
      for (int w = 0; w < int'(v.wt); w++) begin
         @(negedge clk);
         chk($sformatf("R7 addr held v%0d", num), mem_addr, v.eaddr);
         chk($sformatf("R7 strobe held v%0d", num), {30'b0, mem_rd, mem_wr}, {30'b0, v.kind, ~v.kind});
         chk($sformatf("R6 busy wait v%0d", num), {31'b0, busy}, 32'd1);
      end
      mem_ready = 1'b1;
      mem_rdata = v.rdata;
      @(negedge clk);
      mem_ready = 1'b0;
      mem_rdata = 32'hFFFF_FFFF;
      chk($sformatf("R4 R5 zflag v%0d", num), {31'b0, zflag}, {31'b0, v.ez});
      chk($sformatf("R9 done v%0d", num), {31'b0, done}, 32'd1);
      chk($sformatf("R7 strobes off v%0d", num), {30'b0, mem_rd, mem_wr}, 32'd0);
      chk($sformatf("R6 busy off v%0d", num), {31'b0, busy}, 32'd0);
      @(negedge clk);
      chk($sformatf("R9 done single v%0d", num), {31'b0, done}, 32'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R8 reset state
      chk("R8 busy", {31'b0, busy}, 32'd0);
      chk("R8 strobes", {30'b0, mem_rd, mem_wr}, 32'd0);
      chk("R8 zflag", {31'b0, zflag}, 32'd0);
      chk("R8 done", {31'b0, done}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      for (int i = 0; i < NV; i++) run_vec(VECS[i], i);

      // R6: request presented while busy is ignored
      @(negedge clk);
      req_valid = 1'b1; req_kind = 1'b0; base_val = 32'h0000_4000;
      disp_val = 16'h0000; store_val = 32'h1111_2222;
      @(negedge clk);
      req_kind = 1'b1; base_val = 32'h0000_8001; bit_idx = 3'd0;
      @(negedge clk);
      req_valid = 1'b0;
      chk("R6 busy-time request ignored addr", mem_addr, 32'h0000_4000);
      chk("R6 busy-time request ignored kind", {30'b0, mem_rd, mem_wr}, 32'd1);
      mem_ready = 1'b1;
      @(negedge clk);
      mem_ready = 1'b0;
      chk("R5 zflag kept over store", {31'b0, zflag}, 32'd1);
      @(negedge clk);
      chk("R6 no second access", {29'b0, busy, mem_rd, mem_wr}, 32'd0);

      // R4: every lane and index pairing on one pattern
      for (int ln = 0; ln < 4; ln++) begin
         for (int b = 0; b < 8; b += 3) begin
            logic [31:0] pat;
            logic        ez;
            pat = 32'hA5C3_0F96;
            ez  = ~pat[8*ln + b];
            run_vec('{1'b1, 32'h0000_3000, 16'(ln), 3'(b), 32'h0, pat,
                      32'h0000_3000 + 32'(ln), ez, 2'd0}, 100 + ln * 8 + b);
         end
      end

      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end
endmodule